// File: doc/BRIEF.md
# Asynchronous Bus Read Target

This block is the memory side of an asynchronous, strobe-handshaked read bus with a 32-bit data path. A master starts a read by presenting an address, a two-bit transfer size and a read/write level, and then pulls the address strobe and the data strobe low. The target looks up a word in a small internal constant memory. It drives only the byte lanes that the size and the two low address bits select, and pulls both data-size acknowledge lines low together. For addresses inside a configured window it also asserts a cache-inhibit line.

A per-cycle wait count delays the acknowledge, so the master inserts that many wait states. Data, lane enables and acknowledge stay put until the target samples either strobe negated. They are withdrawn at that same clock edge, so a stale acknowledge cannot leak into the next cycle. After a cycle ends, the target stays deaf until it has seen both strobes high.

All inputs are taken as synchronous to `clk`. The lane enables stand in for the output enables of the external data pads. When a lane is not enabled, the data bus is driven to zero on that lane.

Top module: `rdResponder`

## Requirements
- R1: After reset, both acknowledge lines are high, cache-inhibit is high and all four lane enables are zero.
- R2: A cycle is accepted at a rising edge where `asN` and `dsN` are both low, `rwN` is high and the target is idle. `addr`, `siz` and `waitCycles` are captured at that edge.
- R3: The number of bytes requested is 4 when `siz`=00, and equals `siz` otherwise. Byte offset j = `addr[1:0]` maps to lane enable bit 3-j, where bit 3 covers data bits 31:24. The enabled lanes run from the offset upward and are clipped at offset 3.
- R4: The word at index k = `addr[ADDR_W-1:2]` is {k, k^8'h5A, ~k, k+8'h33}, with k taken as 8 bits and bits 31:24 first. Disabled lanes read as zero.
- R5: If the accept edge counts as edge 1, the acknowledge is low after edge W+1, where W is the captured wait count.
- R6: Both acknowledge lines always carry the same level.
- R7: While acknowledging, `cacheInhN` is low exactly when the word index lies in the range NC_LO..NC_HI inclusive.
- R8: While both strobes stay low, the acknowledge, lane enables and data hold steady.
- R9: At the first rising edge that samples either strobe high, the acknowledge goes high, the lane enables go to zero and cache-inhibit goes high.
- R10: After a cycle ends, no new cycle is accepted until both strobes have been sampled high together.
- R11: A cycle with `rwN` low gets no acknowledge and drives no lanes.
- R12: If a strobe is negated during the wait count, the cycle is dropped with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| rwN | input | 1 | High for read, low for write |
| siz | input | 2 | Transfer size code |
| addr | input | ADDR_W | Byte address |
| waitCycles | input | WAIT_W | Wait states to insert before acknowledge |
| busData | output | 32 | Read data, zero on disabled lanes |
| busLaneOe | output | 4 | Per-lane output enable, bit 3 = bits 31:24 |
| ackN | output | 2 | Data-size acknowledge pair, active low |
| cacheInhN | output | 1 | Cache-inhibit, active low |

## Verification
The assertions assume that `rwN`, `siz`, `addr` and `waitCycles` stay steady from the accept edge until the strobes are released. They also assume that every input meets setup around the rising clock edge. The stimulus changes inputs only on falling edges and holds the cycle attributes fixed for each whole transfer. Strobes are released one at a time, alternating which one goes first. Aborts and write cycles are run only while the target is idle and both strobes start high.

// File: rtl/rdResponder_pkg.sv
package rdResponder_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RESP  = 2'd2,
    ST_REARM = 2'd3
  } rspState_t;

  typedef struct packed {
    logic capture;
    logic drive;
  } ctlStrobes_t;

  function automatic logic [3:0] laneMask(input logic [1:0] sizCode, input logic [1:0] off);
    logic [3:0] m;
    int nBytes;
    m = '0;
    nBytes = (sizCode == 2'b00) ? 4 : int'(sizCode);
    for (int j = 0; j < 4; j++) begin
      if (j >= int'(off) && j < int'(off) + nBytes) m[3-j] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/rdCtl.sv
module rdCtl
  import rdResponder_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rwN,
  input  logic [WAIT_W-1:0] waitCycles,
  output ctlStrobes_t       strobes
);

  rspState_t state, nextState;
  logic [WAIT_W-1:0] cnt, nextCnt;
  logic startReq, strobeGone, bothHigh;

  assign startReq   = !asN && !dsN && rwN;
  assign strobeGone = asN || dsN;
  assign bothHigh   = asN && dsN;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobes.capture = 1'b1;
          nextCnt = waitCycles;
          nextState = (waitCycles == '0) ? ST_RESP : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (strobeGone) nextState = ST_REARM;
        else if (cnt == WAIT_W'(1)) nextState = ST_RESP;
        else nextCnt = cnt - WAIT_W'(1);
      end
      ST_RESP: begin
        strobes.drive = 1'b1;
        if (strobeGone) nextState = ST_REARM;
      end
      default: begin
        if (bothHigh) nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

endmodule

// File: rtl/rdDatapath.sv
module rdDatapath
  import rdResponder_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NC_LO  = 48,
  parameter int NC_HI  = 55
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              driveNow,
  input  logic [1:0]        siz,
  input  logic [ADDR_W-1:0] addr,
  output logic [31:0]       busData,
  output logic [3:0]        busLaneOe,
  output logic              ncHit
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idxQ;
  logic [1:0]       offQ;
  logic [1:0]       sizQ;
  logic [31:0]      word;
  logic [3:0]       lanes;
  logic [31:0]      byteMask;

  function automatic logic [31:0] wordAt(input logic [IDX_W-1:0] idx);
    logic [IDX_W+7:0] wide;
    logic [7:0] k;
    wide = {8'b0, idx};
    k = wide[7:0];
    return {k, k ^ 8'h5A, ~k, k + 8'h33};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      offQ <= '0;
      sizQ <= '0;
    end else if (strobes.capture) begin
      idxQ <= addr[ADDR_W-1:2];
      offQ <= addr[1:0];
      sizQ <= siz;
    end
  end

  assign word  = wordAt(idxQ);
  assign lanes = laneMask(sizQ, offQ);

  generate
    for (genvar b = 0; b < 4; b++) begin : g_lane
      assign byteMask[8*b+7:8*b] = {8{lanes[b] & driveNow}};
    end
  endgenerate

  assign busData   = word & byteMask;
  assign busLaneOe = driveNow ? lanes : 4'b0000;
  assign ncHit     = driveNow && (int'(idxQ) >= NC_LO) && (int'(idxQ) <= NC_HI);

endmodule

// File: rtl/rdResponder.sv
module rdResponder
  import rdResponder_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WAIT_W = 4,
  parameter int NC_LO  = 48,
  parameter int NC_HI  = 55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rwN,
  input  logic [1:0]        siz,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WAIT_W-1:0] waitCycles,
  output logic [31:0]       busData,
  output logic [3:0]        busLaneOe,
  output logic [1:0]        ackN,
  output logic              cacheInhN
);

  ctlStrobes_t strobes;
  logic ncHit;

  rdCtl #(.WAIT_W(WAIT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .rwN(rwN),
    .waitCycles(waitCycles), .strobes(strobes)
  );

  rdDatapath #(.ADDR_W(ADDR_W), .NC_LO(NC_LO), .NC_HI(NC_HI)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .driveNow(strobes.drive),
    .siz(siz), .addr(addr), .busData(busData), .busLaneOe(busLaneOe), .ncHit(ncHit)
  );

  assign ackN      = {2{~strobes.drive}};
  assign cacheInhN = ~ncHit;

endmodule

// File: rtl/rdResponderChk.sv
module rdResponderChk #(
  parameter int ADDR_W = 8,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              asN,
  input logic              dsN,
  input logic              rwN,
  input logic [1:0]        siz,
  input logic [ADDR_W-1:0] addr,
  input logic [WAIT_W-1:0] waitCycles,
  input logic [31:0]       busData,
  input logic [3:0]        busLaneOe,
  input logic [1:0]        ackN,
  input logic              cacheInhN
);

  logic unusedIns;
  assign unusedIns = ^{siz, addr, waitCycles};

  a_r6_ack_pair: assert property (@(posedge clk) disable iff (!rstN)
    ackN[0] == ackN[1]);

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (ackN == 2'b11) |-> (busLaneOe == 4'b0000 && cacheInhN && busData == 32'h0));

  a_r3_lanes_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ackN == 2'b00) |-> (busLaneOe != 4'b0000));

  a_r8_hold_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ackN == 2'b00 && !asN && !dsN) |=> (ackN == 2'b00));

  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ackN == 2'b00) |=> (ackN != 2'b00 || ($stable(busData) && $stable(busLaneOe))));

  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    (ackN == 2'b00 && (asN || dsN)) |=> (ackN == 2'b11 && busLaneOe == 4'b0000));

  a_r11_no_write_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ackN == 2'b11 && !rwN && !asN && !dsN) |=> (ackN == 2'b11));

  a_r10_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (ackN == 2'b00 && dsN && !asN) |=> (ackN == 2'b11) [*2]);

  logic unusedAll;
  assign unusedAll = unusedIns;

endmodule

bind rdResponder rdResponderChk #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_chk (.*);

// File: tb/sim_rdResponder.sv
module sim_rdResponder;

  localparam int ADDR_W = 8;
  localparam int WAIT_W = 4;
  localparam int NC_LO  = 48;
  localparam int NC_HI  = 55;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asN = 1'b1, dsN = 1'b1, rwN = 1'b1;
  logic [1:0] siz = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WAIT_W-1:0] waitCycles = '0;
  logic [31:0] busData;
  logic [3:0]  busLaneOe;
  logic [1:0]  ackN;
  logic        cacheInhN;

  always #4 clk = ~clk;

  rdResponder #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .NC_LO(NC_LO), .NC_HI(NC_HI)) u0 (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .rwN(rwN), .siz(siz), .addr(addr),
    .waitCycles(waitCycles), .busData(busData), .busLaneOe(busLaneOe), .ackN(ackN),
    .cacheInhN(cacheInhN)
  );

  typedef struct {
    logic [31:0] data;
    logic [3:0]  lanes;
    logic        ci;
    int          lat;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int startCyc = 0;
  logic prevAck = 1'b1;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refWord(input int idx);
    logic [7:0] k;
    k = 8'(idx);
    return {k, k ^ 8'h5A, ~k, k + 8'h33};
  endfunction

  function automatic logic [3:0] refLanes(input int s, input int off);
    logic [3:0] m;
    int n;
    m = '0;
    n = (s == 0) ? 4 : s;
    for (int j = off; j < off + n && j < 4; j++) m[3-j] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] laneBits(input logic [3:0] l);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = {8{l[b]}};
    return r;
  endfunction

  always @(posedge clk) cyc++;

  // monitor: pops one expected item per falling acknowledge
  always @(negedge clk) begin
    if (rstN && ackN == 2'b00 && prevAck) begin
      expItem_t e;
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected ack", 32'(ackN), 32'h3);
      end else begin
        e = expQ.pop_front();
        chk(busData == e.data, "R4 data", busData, e.data);
        chk(busLaneOe == e.lanes, "R3 lanes", 32'(busLaneOe), 32'(e.lanes));
        chk((~cacheInhN) == e.ci, "R7 cache-inhibit", 32'(~cacheInhN), 32'(e.ci));
        chk(cyc - startCyc == e.lat, "R5 wait latency", 32'(cyc - startCyc), 32'(e.lat));
      end
    end
    chk(ackN[0] == ackN[1], "R6 pair", 32'(ackN), 32'(ackN[0] ? 2'b11 : 2'b00));
    prevAck = ackN[0];
  end

  task automatic doRead(input int idx, input int off, input int s, input int w, input bit relAs);
    expItem_t e;
    logic [3:0] l;
    int t;
    l = refLanes(s, off);
    e.data  = refWord(idx) & laneBits(l);
    e.lanes = l;
    e.ci    = (idx >= NC_LO && idx <= NC_HI);
    e.lat   = w + 1;
    expQ.push_back(e);
    @(negedge clk);
    addr = ADDR_W'(idx * 4 + off);
    siz = 2'(s);
    rwN = 1'b1;
    waitCycles = WAIT_W'(w);
    asN = 1'b0;
    dsN = 1'b0;
    startCyc = cyc;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (ackN != 2'b00 && t < 40);
    chk(ackN == 2'b00, "R5 ack arrives", 32'(ackN), 32'h0);
    repeat (2) @(negedge clk);
    chk(ackN == 2'b00 && busData == e.data, "R8 hold", busData, e.data);
    if (relAs) asN = 1'b1; else dsN = 1'b1;
    @(negedge clk);
    chk(ackN == 2'b11 && busLaneOe == 4'b0000 && cacheInhN, "R9 release",
        {ackN, busLaneOe, cacheInhN}, {2'b11, 4'b0000, 1'b1});
    asN = 1'b1;
    dsN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ackN == 2'b11 && cacheInhN && busLaneOe == 4'b0000, "R1 reset",
        {ackN, busLaneOe, cacheInhN}, {2'b11, 4'b0000, 1'b1});
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doRead(5,  0, 0, 0, 1'b1);
    doRead(17, 1, 1, 1, 1'b0);
    doRead(50, 2, 2, 3, 1'b1);
    doRead(63, 3, 0, 2, 1'b0);
    doRead(48, 1, 3, 7, 1'b1);
    doRead(55, 0, 2, 0, 1'b0);
    doRead(47, 2, 3, 15, 1'b1);
    doRead(56, 3, 1, 1, 1'b0);

    // R10: data strobe dropped then re-asserted while address strobe held
    doRead(9, 0, 0, 0, 1'b0);
    @(negedge clk);
    addr = ADDR_W'(9 * 4);
    asN = 1'b0;
    dsN = 1'b0;
    startCyc = cyc;
    expQ.push_back('{data: refWord(9), lanes: 4'hF, ci: 1'b0, lat: 1});
    @(negedge clk);
    dsN = 1'b1;
    @(negedge clk);
    dsN = 1'b0;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (ackN != 2'b11) quiet = 1'b0;
      end
      chk(quiet, "R10 no rearm", 32'(ackN), 32'h3);
    end
    asN = 1'b1;
    dsN = 1'b1;
    @(negedge clk);

    // R11: write cycle ignored
    rwN = 1'b0;
    addr = ADDR_W'(12);
    siz = 2'b00;
    waitCycles = '0;
    asN = 1'b0;
    dsN = 1'b0;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (ackN != 2'b11 || busLaneOe != 4'b0000) quiet = 1'b0;
      end
      chk(quiet, "R11 write ignored", {ackN, busLaneOe}, {2'b11, 4'b0000});
    end
    asN = 1'b1;
    dsN = 1'b1;
    rwN = 1'b1;
    @(negedge clk);

    // R12: abort during wait states
    addr = ADDR_W'(20 * 4);
    waitCycles = WAIT_W'(8);
    asN = 1'b0;
    dsN = 1'b0;
    repeat (3) @(negedge clk);
    asN = 1'b1;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (ackN != 2'b11) quiet = 1'b0;
      end
      chk(quiet, "R12 abort", 32'(ackN), 32'h3);
    end
    dsN = 1'b1;
    @(negedge clk);

    doRead(30, 0, 0, 2, 1'b1);
    chk(expQ.size() == 0, "R2 all responses seen", 32'(expQ.size()), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule